// File: doc/BRIEF.md
# Cascaded Event Counter Bank

This block is a bank of wide event counters. Each counter has its own control word. A counter can run freely. It can also be held idle and armed, so that it starts the cycle after another counter overflows. Counters are grouped in adjacent pairs (0/1, 2/3, ...). A counter with its cascade bit set waits for its pair partner to overflow.

The last pair holds two special counters. Their pair cascade bit has no effect. Instead, two designated target counters (0 and 2 by default) each carry two cross-start bits. One bit selects the first special counter as their starter, the other selects the second.

Each counter sees two event pulse lines, one per logical thread. A thread-select field in the control word picks which lines count. Overflow is the carry out of the counter width. It sets a sticky flag, and it can feed the shared, level-sensitive interrupt line. A force-overflow bit makes every qualified event count as an overflow. A simple write port loads control words and counts, and clears flags.

Top module: `cevc_bank`

## Requirements
- R1: After a synchronous reset, every count, control word, armed state and overflow flag is zero, and `irq_o` is low.
- R2: Control bits [5:4] select the threads: bit 4 counts `ev_t0_i`, bit 5 counts `ev_t1_i`. With both set, a cycle with both pulses adds 2, and with the field at 00 nothing is counted.
- R3: A counter counts only when it is running, meaning either its enable bit (control bit 0) is set or it has been started by a trigger. Otherwise its value holds.
- R4: A counter with cascade bit (control bit 1) set and enable clear starts counting in the cycle after the overflow of its pair partner (index XOR 1). Events in the overflow cycle itself are not counted.
- R5: The cascade bit of either special counter (the last two indices) never starts it, even when the other special counter overflows.
- R6: Control bit 6 of target counter 0 or 2 starts that counter after the first special counter overflows, and bit 7 starts it after the second special counter overflows. These bits are ignored on every other counter.
- R7: Overflow is the carry out of the 40-bit counter. Preloading 0xFF_FFFF_F000 gives the overflow on exactly the 4096th qualified event.
- R8: An overflow flag stays set until a flag-clear write (kind 2) to that counter.
- R9: `irq_o` equals the OR of all overflow flags whose interrupt bit (control bit 2) is set. It changes in the same cycle as the flags.
- R10: With force bit (control bit 3) set on a running counter, every cycle with a nonzero qualified increment is an overflow: it sets the flag and fires triggers, while the count still advances normally.
- R11: A started counter keeps running until its control word is rewritten, which disarms it. Later overflows of the starter have no further effect.
- R12: A write of any kind to a counter in the same cycle as its events drops those events: no count change and no overflow.
- R13: Write kinds are 0 for the control word (data bits [7:0]), 1 for the count (full width) and 2 for the flag clear, with 3 doing nothing. The written value is visible in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_t0_i | input | N | Thread 0 event pulses, one per counter |
| ev_t1_i | input | N | Thread 1 event pulses, one per counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | log2(N) | Counter addressed by the write |
| wr_kind_i | input | 2 | Write kind: 0 control, 1 count, 2 flag clear, 3 none |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | N*CNT_W | All counter values, counter i at bits [i*CNT_W +: CNT_W] |
| ovf_o | output | N | Sticky overflow flags |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a cross-start driven by a special counter reaching its natural carry, since that takes thousands of qualified events. The bench preloads 0xFF_FFFF_F000 and streams exactly 4095 events, then one more. While doing so it keeps events flowing to the armed target and to a non-target with a cross-start bit, which shows that nothing moves early or at all. Same-cycle collisions of writes with events, and of triggers with control rewrites, come from the random phase. That phase loads counts near the top of the range so that carries occur often.

// File: rtl/cevc_pkg.sv
package cevc_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic [1:0] xt;        // cross-start select (targets only)
    logic [1:0] thr;       // thread select
    logic       force_ovf;
    logic       irq_en;
    logic       casc;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    WR_CTRL = 2'd0,
    WR_CNT  = 2'd1,
    WR_CLR  = 2'd2,
    WR_NOP  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cevc_qual.sv
module cevc_qual (
  input  logic [1:0] thr_i,
  input  logic       ev_t0_i,
  input  logic       ev_t1_i,
  output logic [1:0] inc_o
);
  assign inc_o = {1'b0, thr_i[0] & ev_t0_i} + {1'b0, thr_i[1] & ev_t1_i};
endmodule

// File: rtl/cevc_slice.sv
module cevc_slice
  import cevc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_t0_i,
  input  logic             ev_t1_i,
  input  logic             hit_i,
  input  wr_kind_e         kind_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             ovf_p_o,
  output logic             casc_o,
  output logic [1:0]       xt_o,
  output logic             irq_en_o,
  output logic             irq_req_d_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             started_q, started_d;
  logic             flag_q, flag_d;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;
  logic             active;
  logic             ovf_p;

  cevc_qual u_qual (
    .thr_i   (ctrl_q.thr),
    .ev_t0_i (ev_t0_i),
    .ev_t1_i (ev_t1_i),
    .inc_o   (inc)
  );

  assign active = ctrl_q.en | started_q;
  assign sum    = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
  assign ovf_p  = active & ~hit_i &
                  (sum[CNT_W] | (ctrl_q.force_ovf & (inc != 2'd0)));

  always_comb begin
    ctrl_d    = ctrl_q;
    cnt_d     = cnt_q;
    started_d = started_q | trig_i;
    flag_d    = flag_q | ovf_p;
    if (hit_i) begin
      case (kind_i)
        WR_CTRL: begin
          ctrl_d    = ctrl_t'(data_i[CTRL_W-1:0]);
          started_d = 1'b0;
        end
        WR_CNT:  cnt_d  = data_i;
        WR_CLR:  flag_d = 1'b0;
        default: ;
      endcase
    end else if (active) begin
      cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      cnt_q     <= cnt_d;
      started_q <= started_d;
      flag_q    <= flag_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign flag_o      = flag_q;
  assign ovf_p_o     = ovf_p;
  assign casc_o      = ctrl_q.casc;
  assign xt_o        = ctrl_q.xt;
  assign irq_en_o    = ctrl_q.irq_en;
  assign irq_req_d_o = flag_d & ctrl_d.irq_en;

  // R13
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i && kind_i == WR_CNT |=> cnt_q == $past(data_i));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.en || started_q) && !hit_i |=> $stable(cnt_q));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q && !(hit_i && kind_i == WR_CLR) |=> flag_q);
  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(started_q) |-> $past(trig_i));
  // R12
  wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i && kind_i != WR_CNT |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/cevc_route.sv
module cevc_route #(
  parameter int N     = 8,
  parameter int SPEC0 = N - 2,
  parameter int SPEC1 = N - 1,
  parameter int TGT0  = 0,
  parameter int TGT1  = 2
) (
  input  logic [N-1:0] ovf_p_i,
  input  logic [N-1:0] casc_i,
  input  logic [N-1:0] xt0_i,
  input  logic [N-1:0] xt1_i,
  output logic [N-1:0] trig_o
);
  for (genvar i = 0; i < N; i++) begin : g_rt
    localparam int   PAIR    = i ^ 1;
    localparam logic PAIR_OK = !((i == SPEC0) || (i == SPEC1));
    localparam logic IS_TGT  = (i == TGT0) || (i == TGT1);
    logic pair_t, cross_t;
    assign pair_t  = casc_i[i] & ovf_p_i[PAIR] & PAIR_OK;
    assign cross_t = ((xt0_i[i] & ovf_p_i[SPEC0]) |
                      (xt1_i[i] & ovf_p_i[SPEC1])) & IS_TGT;
    assign trig_o[i] = pair_t | cross_t;
  end
endmodule

// File: rtl/cevc_bank.sv
module cevc_bank
  import cevc_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 40,
  parameter int SPEC0 = N - 2,
  parameter int SPEC1 = N - 1,
  parameter int TGT0  = 0,
  parameter int TGT1  = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       ev_t0_i,
  input  logic [N-1:0]       ev_t1_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [1:0]         wr_kind_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [N*CNT_W-1:0] cnt_o,
  output logic [N-1:0]       ovf_o,
  output logic               irq_o
);
  logic [N-1:0] ovf_p, casc, xt0, xt1, irq_en, irq_req_d, trig;
  logic         irq_q;
  wr_kind_e     kind;

  assign kind = wr_kind_e'(wr_kind_i);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [1:0] xt_w;
    logic       hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));
    cevc_slice #(.CNT_W(CNT_W)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .ev_t0_i     (ev_t0_i[i]),
      .ev_t1_i     (ev_t1_i[i]),
      .hit_i       (hit),
      .kind_i      (kind),
      .data_i      (wr_data_i),
      .trig_i      (trig[i]),
      .cnt_o       (cnt_o[i*CNT_W +: CNT_W]),
      .flag_o      (ovf_o[i]),
      .ovf_p_o     (ovf_p[i]),
      .casc_o      (casc[i]),
      .xt_o        (xt_w),
      .irq_en_o    (irq_en[i]),
      .irq_req_d_o (irq_req_d[i])
    );
    assign xt0[i] = xt_w[0];
    assign xt1[i] = xt_w[1];
  end

  cevc_route #(
    .N(N), .SPEC0(SPEC0), .SPEC1(SPEC1), .TGT0(TGT0), .TGT1(TGT1)
  ) u_route (
    .ovf_p_i (ovf_p),
    .casc_i  (casc),
    .xt0_i   (xt0),
    .xt1_i   (xt1),
    .trig_o  (trig)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |irq_req_d;
  end
  assign irq_o = irq_q;

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(ovf_o & irq_en));
  // R5
  spec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trig[SPEC0] && !trig[SPEC1]);
endmodule

// File: tb/test_cevc_bank.sv
module test_cevc_bank;
  localparam int N = 8;
  localparam int W = 40;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] ev_t0 = '0, ev_t1 = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [1:0] wr_kind = '0;
  logic [W-1:0] wr_data = '0;
  logic [N*W-1:0] cnt;
  logic [N-1:0] ovf;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_cnt [N];
  logic [7:0]   m_ctl [N];
  logic         m_st  [N];
  logic         m_fl  [N];

  always #4 clk = ~clk;

  cevc_bank i_cevc_bank (
    .clk(clk), .rst(rst), .ev_t0_i(ev_t0), .ev_t1_i(ev_t1),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_kind_i(wr_kind),
    .wr_data_i(wr_data), .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq)
  );

  function automatic logic [W-1:0] dut_cnt(int i);
    return cnt[i*W +: W];
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < N; i++) r |= m_fl[i] & m_ctl[i][2];
    return r;
  endfunction

  task automatic model_step(logic [N-1:0] t0, logic [N-1:0] t1, logic we,
                            int idx, logic [1:0] kind, logic [W-1:0] data);
    logic [1:0] inc [N];
    logic op [N];
    logic tr [N];
    logic [W:0] sum [N];
    for (int i = 0; i < N; i++) begin
      logic act, hit;
      inc[i] = {1'b0, m_ctl[i][4] & t0[i]} + {1'b0, m_ctl[i][5] & t1[i]};
      act = m_ctl[i][0] | m_st[i];
      hit = we && (idx == i);
      sum[i] = {1'b0, m_cnt[i]} + {{(W-1){1'b0}}, inc[i]};
      op[i] = act && !hit && (sum[i][W] || (m_ctl[i][3] && inc[i] != 0));
    end
    for (int i = 0; i < N; i++) begin
      tr[i] = 1'b0;
      if (i != N-2 && i != N-1) tr[i] = m_ctl[i][1] & op[i^1];
      if (i == 0 || i == 2) tr[i] |= (m_ctl[i][6] & op[N-2]) | (m_ctl[i][7] & op[N-1]);
    end
    for (int i = 0; i < N; i++) begin
      logic act, hit;
      act = m_ctl[i][0] | m_st[i];
      hit = we && (idx == i);
      m_fl[i] = m_fl[i] | op[i];
      m_st[i] = m_st[i] | tr[i];
      if (hit) begin
        case (kind)
          2'd0: begin m_ctl[i] = data[7:0]; m_st[i] = 1'b0; end
          2'd1: m_cnt[i] = data;
          2'd2: m_fl[i] = 1'b0;
          default: ;
        endcase
      end else if (act) begin
        m_cnt[i] = sum[i][W-1:0];
      end
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < N; i++) begin
      n_chk++;
      if (dut_cnt(i) !== m_cnt[i]) begin
        n_bad++;
        $display("FAIL %s cnt[%0d] actual %h expected %h", tag, i, dut_cnt(i), m_cnt[i]);
      end
      n_chk++;
      if (ovf[i] !== m_fl[i]) begin
        n_bad++;
        $display("FAIL %s flag[%0d] actual %b expected %b", tag, i, ovf[i], m_fl[i]);
      end
    end
    n_chk++;
    if (irq !== exp_irq()) begin
      n_bad++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq());
    end
  endtask

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] t0, logic [N-1:0] t1, logic we, int idx,
                      logic [1:0] kind, logic [W-1:0] data, string tag);
    ev_t0 = t0; ev_t1 = t1; wr_en = we;
    wr_idx = idx[2:0]; wr_kind = kind; wr_data = data;
    model_step(t0, t1, we, idx, kind, data);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(int idx, logic [1:0] kind, logic [W-1:0] data, string tag);
    step('0, '0, 1'b1, idx, kind, data, tag);
  endtask

  task automatic ev(logic [N-1:0] t0, logic [N-1:0] t1, string tag);
    step(t0, t1, 1'b0, 0, 2'd3, '0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = '0; m_ctl[i] = '0; m_st[i] = 1'b0; m_fl[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset");

    // R13 count write, R2 both threads
    wr(1, 2'd1, 40'd100, "R13");
    chk("R13 load", dut_cnt(1), 40'd100);
    wr(1, 2'd0, 40'h31, "R2");
    repeat (3) ev(8'h02, 8'h02, "R2");
    chk("R2 both threads", dut_cnt(1), 40'd106);
    wr(3, 2'd0, 40'h11, "R2");
    repeat (2) ev(8'h08, 8'h08, "R2");
    ev(8'h00, 8'h08, "R2");
    chk("R2 thread0 only", dut_cnt(3), 40'd2);

    // R3 not enabled
    wr(4, 2'd0, 40'h30, "R3");
    repeat (2) ev(8'h10, 8'h10, "R3");
    chk("R3 idle holds", dut_cnt(4), 40'd0);

    // R4 pair cascade 4 -> 5
    wr(4, 2'd1, MAXV - 1, "R4");
    wr(4, 2'd0, 40'h11, "R4");
    wr(5, 2'd0, 40'h32, "R4");
    ev(8'h30, 8'h30, "R4");
    ev(8'h30, 8'h30, "R4");
    chk("R4 no count in trigger cycle", dut_cnt(5), 40'd0);
    chk("R4 partner flag", {39'd0, ovf[4]}, 40'd1);
    ev(8'h20, 8'h20, "R4");
    chk("R4 counts after start", dut_cnt(5), 40'd2);

    // R5 special cascade bit ignored
    wr(6, 2'd1, MAXV, "R5");
    wr(6, 2'd0, 40'h11, "R5");
    wr(7, 2'd0, 40'h12, "R5");
    ev(8'hC0, 8'h00, "R5");
    repeat (2) ev(8'h80, 8'h00, "R5");
    chk("R5 special not started", dut_cnt(7), 40'd0);

    // R7 / R6 / R9 cross start from first special to target 0
    wr(6, 2'd2, '0, "R8");
    wr(6, 2'd1, 40'hFF_FFFF_F000, "R7");
    wr(6, 2'd0, 40'h15, "R7");
    wr(0, 2'd0, 40'h64, "R6");
    wr(3, 2'd0, 40'h50, "R6");
    repeat (4095) ev(8'h48, 8'h01, "R7");
    chk("R7 no flag after 4095", {39'd0, ovf[6]}, 40'd0);
    chk("R7 count at top", dut_cnt(6), MAXV);
    chk("R6 target waits", dut_cnt(0), 40'd0);
    ev(8'h48, 8'h01, "R7");
    chk("R7 flag on 4096th", {39'd0, ovf[6]}, 40'd1);
    chk("R9 irq raised", {39'd0, irq}, 40'd1);
    chk("R6 trigger cycle", dut_cnt(0), 40'd0);
    ev(8'h08, 8'h01, "R6");
    chk("R6 target counts", dut_cnt(0), 40'd1);
    chk("R6 non-target ignores", dut_cnt(3), 40'd2);
    ev(8'h00, 8'h00, "R9");
    chk("R9 irq level", {39'd0, irq}, 40'd1);
    wr(6, 2'd2, '0, "R8");
    chk("R8 flag cleared", {39'd0, ovf[6]}, 40'd0);
    chk("R9 irq dropped", {39'd0, irq}, 40'd0);

    // R11 started stays, rewrite disarms
    wr(6, 2'd1, MAXV, "R11");
    ev(8'h40, 8'h01, "R11");
    chk("R11 still running", dut_cnt(0), 40'd2);
    wr(0, 2'd0, 40'h64, "R11");
    ev(8'h00, 8'h01, "R11");
    chk("R11 disarmed", dut_cnt(0), 40'd2);

    // R6 second special to target 2
    wr(2, 2'd0, 40'h90, "R6");
    wr(7, 2'd0, 40'h11, "R6");
    wr(7, 2'd1, MAXV, "R6");
    ev(8'h84, 8'h00, "R6");
    ev(8'h04, 8'h00, "R6");
    chk("R6 second special start", dut_cnt(2), 40'd1);

    // R10 force overflow
    wr(4, 2'd2, '0, "R10");
    wr(4, 2'd0, 40'h19, "R10");
    ev(8'h10, 8'h00, "R10");
    chk("R10 forced flag", {39'd0, ovf[4]}, 40'd1);
    chk("R10 count advances", dut_cnt(4), 40'd1);

    // R12 write beats event
    step(8'h02, 8'h02, 1'b1, 1, 2'd1, 40'd500, "R12");
    chk("R12 count write wins", dut_cnt(1), 40'd500);
    step(8'h02, 8'h02, 1'b1, 1, 2'd0, 40'h31, "R12");
    chk("R12 ctrl write drops event", dut_cnt(1), 40'd500);
    wr(6, 2'd2, '0, "R12");
    wr(6, 2'd1, MAXV, "R12");
    step(8'h40, 8'h00, 1'b1, 6, 2'd3, '0, "R12");
    chk("R12 no overflow under write", {39'd0, ovf[6]}, 40'd0);
    chk("R12 count held", dut_cnt(6), MAXV);

    // random mix: R2 R3 R4 R6 R8 R10 R11 R12
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] a, b;
      logic we;
      int idx;
      logic [1:0] kind;
      logic [W-1:0] d;
      a = N'($urandom);
      b = N'($urandom);
      we = ($urandom % 6) == 0;
      idx = $urandom % N;
      kind = 2'($urandom);
      if (kind == 2'd1) d = ($urandom % 2) ? (MAXV - 40'($urandom % 8)) : 40'($urandom);
      else d = 40'($urandom % 256);
      step(a, b, we, idx, kind, d, "R4 R6 R10 R12 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule